// File: doc/BRIEF.md
# External Bus Cycle Controller

This controller runs one external memory access at a time on behalf of an internal requester. The requester presents an address, write data and a direction bit, and raises a start strobe while the controller reports itself idle. The controller then plays out a fixed sequence on the external pins. First comes an address-latch pulse. Next is an optional delay clock, followed by an active-low read or write command. Last comes a short turnaround phase before it accepts the next request. For a read it returns a one-clock done pulse together with the captured read data.

The command phase is stretched in two ways. A programmed count of waitstates (0 to 15) always applies. The external device's active-low READY input can add more. READY can be taken directly as a synchronous input or through a two-flop synchronizer, and it can be ignored entirely. On the shared bus, the address appears on the data lines during the latch pulse. The data lines then carry write data or are released for the device to drive. After the command, a turnaround clock releases the bus, and an optional extra tristate clock can follow it. In separate-bus mode the address has its own pins, and no turnaround clock is added unless the extra tristate clock is enabled. All configuration is taken at the clock where a request is accepted.

Top module: `ebc_ctrl`

## Requirements
- R1: After reset, idle_o=1, done_o=0, ale_o=0, rd_no=1, wr_no=1 and ad_oe_o=0.
- R2: A request is accepted only at a clock edge where idle_o=1 and start_i=1. ale_o is then high for exactly the next clock and for no other clock of that access. A start_i raised while idle_o=0 starts nothing.
- R3: addr_o holds the accepted address from the latch clock until the next acceptance. With cfg_mux_i=1, the latch clock also shows ad_o equal to the zero-extended address, with ad_oe_o=1.
- R4: The command (rd_no low for we_i=0, wr_no low for we_i=1) begins in the clock right after the latch clock when cfg_rwdly_i=0, and one clock later when cfg_rwdly_i=1.
- R5: With cfg_rdy_en_i=0, the command lasts exactly cfg_ws_i+1 clocks whatever ready_ni does.
- R6: With cfg_rdy_en_i=1 and cfg_rdy_async_i=0, ready_ni is sampled at the end of each command clock from clock cfg_ws_i+1 on. A sampled 1 adds one clock and a sampled 0 ends the command.
- R7: With cfg_rdy_en_i=1 and cfg_rdy_async_i=1, the sampled value is ready_ni as it stood two clocks earlier, taken through two flops.
- R8: During a read command ad_oe_o=0, and rdata_o takes the lower data bits of ad_i at the edge that ends the command. During a write command ad_oe_o=1 and ad_o equals the zero-extended write data.
- R9: done_o is high for exactly one clock: the clock right after the last command clock.
- R10: idle_o returns cfg_mux_i+cfg_tri_i clocks after the clock that follows the last command clock. ad_oe_o=0 in those turnaround clocks, and neither command nor ale_o is active while idle_o=1.
- R11: Changing any cfg input after acceptance has no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken when idle |
| addr_i | input | AW | Request address |
| wdata_i | input | DW | Request write data |
| we_i | input | 1 | 1 = write, 0 = read |
| cfg_ws_i | input | WSW | Programmed waitstates |
| cfg_rwdly_i | input | 1 | Delay the command by one clock |
| cfg_mux_i | input | 1 | 1 = shared address/data bus |
| cfg_tri_i | input | 1 | Add the extra tristate clock |
| cfg_rdy_en_i | input | 1 | Let READY stretch the command |
| cfg_rdy_async_i | input | 1 | Take READY through the synchronizer |
| idle_o | output | 1 | Ready to accept a request |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DW | Captured read data |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Active-low read command |
| wr_no | output | 1 | Active-low write command |
| addr_o | output | AW | Separate address pins |
| ad_o | output | BW | Address/data bus output value |
| ad_oe_o | output | 1 | Address/data bus output enable |
| ad_i | input | BW | Address/data bus input value |
| ready_ni | input | 1 | Active-low READY from the device |

## Verification
The properties assume that the requester looks at idle_o before it counts on a start, and that the device drives the data lines only while the read command is low. The bench keeps to both. Its memory model reacts only to the command pins. It pulls READY low once a programmed number of command clocks has passed, and releases READY in the clock after the command rises. On every access the bench also raises start_i and scrambles every configuration input while the controller is busy. These values could only matter if the controller wrongly accepted them, so the checks on ale_o, the command length and the turnaround length expose any such leak.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ALE  = 3'd1,
    ST_DLY  = 3'd2,
    ST_CMD  = 3'd3,
    ST_MUX  = 3'd4,
    ST_TRI  = 3'd5
  } ebc_state_e;

  typedef struct packed {
    logic rwdly;
    logic mux;
    logic tris;
    logic rdy_en;
    logic rdy_async;
  } ebc_mode_t;
endpackage

// File: rtl/ebc_rdy_sync.sv
module ebc_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_ni,
  input  logic async_i,
  output logic rdy_seen_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], ready_ni};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
    end else begin
      sync_q <= sync_d;
    end
  end

  always_comb begin
    if (async_i) begin
      rdy_seen_o = ~sync_q[LAST];
    end else begin
      rdy_seen_o = ~ready_ni;
    end
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int WSW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [WSW-1:0]  cfg_ws_i,
  input  ebc_mode_t       cfg_mode_i,
  input  logic            rdy_seen_i,
  output ebc_state_e      state_o,
  output ebc_mode_t       mode_o,
  output logic            accept_o,
  output logic            term_o,
  output logic            done_o
);
  localparam logic [WSW-1:0] ONE = WSW'(1);

  ebc_state_e     state_q, state_d;
  logic [WSW-1:0] cnt_q, cnt_d;
  logic [WSW-1:0] ws_q;
  ebc_mode_t      mode_q;
  logic           done_q;
  logic           accept;
  logic           term;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    term    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) state_d = ST_ALE;
      end
      ST_ALE: begin
        cnt_d   = ws_q;
        state_d = mode_q.rwdly ? ST_DLY : ST_CMD;
      end
      ST_DLY: begin
        state_d = ST_CMD;
      end
      ST_CMD: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - ONE;
        end else if (!mode_q.rdy_en || rdy_seen_i) begin
          term = 1'b1;
          if (mode_q.mux)       state_d = ST_MUX;
          else if (mode_q.tris) state_d = ST_TRI;
          else                  state_d = ST_IDLE;
        end
      end
      ST_MUX: begin
        state_d = mode_q.tris ? ST_TRI : ST_IDLE;
      end
      ST_TRI: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= term;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q   <= '0;
      mode_q <= '0;
    end else if (accept) begin
      ws_q   <= cfg_ws_i;
      mode_q <= cfg_mode_i;
    end
  end

  assign state_o  = state_q;
  assign mode_o   = mode_q;
  assign accept_o = accept;
  assign term_o   = term;
  assign done_o   = done_q;
endmodule

// File: rtl/ebc_bus_drv.sv
module ebc_bus_drv
  import ebc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ebc_state_e    state_i,
  input  logic          mux_i,
  input  logic          accept_i,
  input  logic          term_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic [BW-1:0] ad_i,
  output logic          ale_o,
  output logic          rd_no,
  output logic          wr_no,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          we_q;
  logic [DW-1:0] rdata_q;
  logic [BW-1:0] addr_ext;
  logic [BW-1:0] data_ext;
  logic          in_ale;
  logic          in_cmd;
  logic          data_phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      we_q    <= we_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (term_i && !we_q) begin
      rdata_q <= ad_i[DW-1:0];
    end
  end

  always_comb begin
    addr_ext           = '0;
    addr_ext[AW-1:0]   = addr_q;
    data_ext           = '0;
    data_ext[DW-1:0]   = wdata_q;
  end

  always_comb begin
    in_ale     = (state_i == ST_ALE);
    in_cmd     = (state_i == ST_CMD);
    data_phase = (state_i == ST_DLY) || in_cmd || (in_ale && !mux_i);
    ale_o      = in_ale;
    rd_no      = ~(in_cmd && !we_q);
    wr_no      = ~(in_cmd && we_q);
    ad_oe_o    = (in_ale && mux_i) || (data_phase && we_q);
    ad_o       = (in_ale && mux_i) ? addr_ext : data_ext;
  end

  assign addr_o  = addr_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
  import ebc_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int WSW = 4,
  parameter int SYNC_STAGES = 2,
  localparam int BW = (AW > DW) ? AW : DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           we_i,
  input  logic [WSW-1:0] cfg_ws_i,
  input  logic           cfg_rwdly_i,
  input  logic           cfg_mux_i,
  input  logic           cfg_tri_i,
  input  logic           cfg_rdy_en_i,
  input  logic           cfg_rdy_async_i,
  output logic           idle_o,
  output logic           done_o,
  output logic [DW-1:0]  rdata_o,
  output logic           ale_o,
  output logic           rd_no,
  output logic           wr_no,
  output logic [AW-1:0]  addr_o,
  output logic [BW-1:0]  ad_o,
  output logic           ad_oe_o,
  input  logic [BW-1:0]  ad_i,
  input  logic           ready_ni
);
  logic [1:0]  rst_sync_q;
  logic        rst_n;
  ebc_mode_t   cfg_mode;
  ebc_mode_t   mode;
  ebc_state_e  state;
  logic        accept;
  logic        term;
  logic        rdy_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  always_comb begin
    cfg_mode.rwdly     = cfg_rwdly_i;
    cfg_mode.mux       = cfg_mux_i;
    cfg_mode.tris      = cfg_tri_i;
    cfg_mode.rdy_en    = cfg_rdy_en_i;
    cfg_mode.rdy_async = cfg_rdy_async_i;
  end

  ebc_rdy_sync #(.STAGES(SYNC_STAGES)) i_rdy_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .ready_ni   (ready_ni),
    .async_i    (mode.rdy_async),
    .rdy_seen_o (rdy_seen)
  );

  ebc_seq #(.WSW(WSW)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .start_i    (start_i),
    .cfg_ws_i   (cfg_ws_i),
    .cfg_mode_i (cfg_mode),
    .rdy_seen_i (rdy_seen),
    .state_o    (state),
    .mode_o     (mode),
    .accept_o   (accept),
    .term_o     (term),
    .done_o     (done_o)
  );

  ebc_bus_drv #(.AW(AW), .DW(DW), .BW(BW)) i_bus_drv (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .state_i  (state),
    .mux_i    (mode.mux),
    .accept_i (accept),
    .term_i   (term),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .we_i     (we_i),
    .ad_i     (ad_i),
    .ale_o    (ale_o),
    .rd_no    (rd_no),
    .wr_no    (wr_no),
    .addr_o   (addr_o),
    .ad_o     (ad_o),
    .ad_oe_o  (ad_oe_o),
    .rdata_o  (rdata_o)
  );

  assign idle_o = (state == ST_IDLE);
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic idle_o,
  input logic done_o,
  input logic ale_o,
  input logic rd_no,
  input logic wr_no,
  input logic ad_oe_o
);
  AST_ALE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o); // R2

  AST_ALE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> $past(idle_o && start_i)); // R2

  AST_NO_CMD_IN_ALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no && wr_no)); // R4

  AST_READ_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o); // R8

  AST_DONE_FOLLOWS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!rd_no || !wr_no)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (rd_no && wr_no && !ale_o)); // R10
endmodule

bind ebc_ctrl ebc_chk i_ebc_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .idle_o  (idle_o),
  .done_o  (done_o),
  .ale_o   (ale_o),
  .rd_no   (rd_no),
  .wr_no   (wr_no),
  .ad_oe_o (ad_oe_o)
);

// File: tb/test_ebc_ctrl.sv
`timescale 1ns/1ps
module test_ebc_ctrl;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WSW = 4;
  localparam int BW = 16;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [AW-1:0]  addr_i = '0;
  logic [DW-1:0]  wdata_i = '0;
  logic           we_i = 1'b0;
  logic [WSW-1:0] cfg_ws_i = '0;
  logic           cfg_rwdly_i = 1'b0;
  logic           cfg_mux_i = 1'b0;
  logic           cfg_tri_i = 1'b0;
  logic           cfg_rdy_en_i = 1'b0;
  logic           cfg_rdy_async_i = 1'b0;
  logic           idle_o, done_o, ale_o, rd_no, wr_no, ad_oe_o;
  logic [DW-1:0]  rdata_o;
  logic [AW-1:0]  addr_o;
  logic [BW-1:0]  ad_o;
  logic [BW-1:0]  ad_i = '0;
  logic           ready_ni = 1'b1;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int kcnt = 0;
  logic [BW-1:0] rd_val = '0;

  always #2.5 clk_i = ~clk_i;

  ebc_ctrl #(.AW(AW), .DW(DW), .WSW(WSW)) i_ebc_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .cfg_ws_i(cfg_ws_i),
    .cfg_rwdly_i(cfg_rwdly_i), .cfg_mux_i(cfg_mux_i), .cfg_tri_i(cfg_tri_i),
    .cfg_rdy_en_i(cfg_rdy_en_i), .cfg_rdy_async_i(cfg_rdy_async_i),
    .idle_o(idle_o), .done_o(done_o), .rdata_o(rdata_o), .ale_o(ale_o),
    .rd_no(rd_no), .wr_no(wr_no), .addr_o(addr_o), .ad_o(ad_o),
    .ad_oe_o(ad_oe_o), .ad_i(ad_i), .ready_ni(ready_ni)
  );

  // Memory model: READY low once more than lat command clocks have passed.
  always @(negedge clk_i) begin
    if (!rd_no || !wr_no) begin
      kcnt = kcnt + 1;
      ready_ni = (kcnt > lat) ? 1'b0 : 1'b1;
    end else begin
      kcnt = 0;
      ready_ni = 1'b1;
    end
    ad_i = !rd_no ? rd_val : ~rd_val;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_cycle(input int ws, input int dly, input int mux, input int tris,
                           input int ren, input int asy, input int l, input int we,
                           input int seed);
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int first, len, done_idx, done_cnt, idle_idx, ale_extra, bus_bad, addr_bad;
    int exp_len, rdata_got;
    bit cmd;
    a = AW'(seed * 37 + 5);
    d = DW'(seed * 91 + 3);
    lat = l;
    rd_val = a ^ 16'hA5C3;
    chk(idle_o === 1'b1, "R2 idle before request", int'(idle_o), 1);
    addr_i = a; wdata_i = d; we_i = we[0];
    cfg_ws_i = WSW'(ws); cfg_rwdly_i = dly[0]; cfg_mux_i = mux[0];
    cfg_tri_i = tris[0]; cfg_rdy_en_i = ren[0]; cfg_rdy_async_i = asy[0];
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(ale_o === 1'b1, "R2 latch pulse", int'(ale_o), 1);
    chk(addr_o === a, "R3 address pins", int'(addr_o), int'(a));
    if (mux != 0)
      chk(ad_oe_o === 1'b1 && ad_o === a, "R3 address on shared bus", int'(ad_o), int'(a));
    // Scramble everything while busy (R2, R11).
    start_i = 1'b1; addr_i = ~a; wdata_i = ~d; we_i = ~we[0];
    cfg_ws_i = ~WSW'(ws); cfg_rwdly_i = ~dly[0]; cfg_mux_i = ~mux[0];
    cfg_tri_i = ~tris[0]; cfg_rdy_en_i = ~ren[0]; cfg_rdy_async_i = ~asy[0];
    first = -1; len = 0; done_idx = -1; done_cnt = 0; idle_idx = -1;
    ale_extra = 0; bus_bad = 0; addr_bad = 0; rdata_got = 0;
    for (int idx = 1; idx < 80; idx++) begin
      @(negedge clk_i);
      if (idx == 2) start_i = 1'b0;
      if (ale_o) ale_extra++;
      if (addr_o !== a) addr_bad++;
      cmd = (we != 0) ? !wr_no : !rd_no;
      if (cmd) begin
        if (first < 0) first = idx;
        len++;
        if (we != 0) begin
          if (!(ad_oe_o === 1'b1 && ad_o === d)) bus_bad++;
        end else if (ad_oe_o !== 1'b0) bus_bad++;
      end else if (first >= 0 && ad_oe_o !== 1'b0) bus_bad++;
      if (done_o) begin
        done_cnt++;
        if (done_idx < 0) done_idx = idx;
        rdata_got = int'(rdata_o);
      end
      if (idle_o) begin
        idle_idx = idx;
        break;
      end
    end
    start_i = 1'b0;
    if (ren == 0) exp_len = ws + 1;
    else if (asy != 0) exp_len = (ws + 1 > l + 3) ? ws + 1 : l + 3;
    else exp_len = (ws + 1 > l + 1) ? ws + 1 : l + 1;
    chk(ale_extra == 0, "R2 no second latch pulse", ale_extra, 0);
    chk(addr_bad == 0, "R3 address held", addr_bad, 0);
    chk(first == 1 + dly, "R4 command start", first, 1 + dly);
    if (ren == 0) chk(len == exp_len, "R5 waitstate length", len, exp_len);
    else if (asy == 0) chk(len == exp_len, "R6 sync READY length", len, exp_len);
    else chk(len == exp_len, "R7 async READY length", len, exp_len);
    chk(bus_bad == 0, "R8 bus drive", bus_bad, 0);
    if (we == 0) chk(rdata_got == int'(rd_val), "R8 read data", rdata_got, int'(rd_val));
    chk(done_cnt == 1 && done_idx == first + len, "R9 done timing", done_idx, first + len);
    chk(idle_idx == first + len + mux + tris, "R10 turnaround", idle_idx, first + len + mux + tris);
    chk(idle_idx == 2 + dly + exp_len + mux + tris - 1, "R11 access total",
        idle_idx, 1 + dly + exp_len + mux + tris);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL R2 watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(idle_o === 1'b1 && done_o === 1'b0, "R1 reset idle/done", int'(idle_o), 1);
    chk(ale_o === 1'b0 && rd_no === 1'b1 && wr_no === 1'b1, "R1 reset strobes", int'(ale_o), 0);
    chk(ad_oe_o === 1'b0, "R1 reset bus released", int'(ad_oe_o), 0);
    for (int wi = 0; wi < 4; wi++)
      for (int dly = 0; dly < 2; dly++)
        for (int mux = 0; mux < 2; mux++)
          for (int tris = 0; tris < 2; tris++)
            for (int ren = 0; ren < 2; ren++)
              for (int asy = 0; asy < 2; asy++)
                for (int li = 0; li < 3; li++)
                  for (int we = 0; we < 2; we++) begin
                    int ws, l;
                    ws = (wi == 3) ? 15 : ((wi == 2) ? 3 : wi);
                    l = (li == 0) ? 0 : ((li == 1) ? 3 : 20);
                    seed++;
                    run_cycle(ws, dly, mux, tris, ren, asy, l, we, seed);
                  end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule